// File: doc/BRIEF.md
# Bayer Channel Digital Gain

This block scales a streamed 12-bit raw Bayer image by one of four programmable gains, one for each colour site of the 2×2 mosaic: red, green-on-red-row, green-on-blue-row and blue. Each gain is an unsigned 12-bit number with 4 integer and 8 fraction bits, so 0x100 is a gain of one. The product of pixel and gain is rounded to nearest, scaled back to the pixel grid and clamped to the 12-bit range. Typical use is colour-mask responsivity correction, with the gains written by firmware from a white-balance estimate computed elsewhere.

The colour of each pixel comes from its row and column parity, taken relative to a selectable starting phase. A small row-tracking state machine holds the row parity. It has three states. `ROW_IDLE` holds after reset until a frame starts. `ROW_EVEN` and `ROW_ODD` follow. Its transitions are:
- frame start: any state goes to `ROW_EVEN`.
- line start without frame start: `ROW_IDLE` goes to `ROW_EVEN`, `ROW_EVEN` goes to `ROW_ODD`, and `ROW_ODD` goes to `ROW_EVEN`.
- otherwise the state holds.

A column parity bit is cleared by a line start and flips on every other accepted pixel. The data path has two register stages. The first picks the gain and the second multiplies, rounds and saturates. Valid and the two markers travel alongside the data.

Top module: `bayer_dgain`

## Requirements
- R1: The colour index of a pixel is {row parity XOR phase_sel[1], column parity XOR phase_sel[0]}. Index 0 uses gain_red, 1 uses gain_gr, 2 uses gain_gb and 3 uses gain_blue. So phase_sel 0 puts red first, 1 puts green-on-red first, 2 puts green-on-blue first and 3 puts blue first.
- R2: Column parity is 0 on a pixel that has in_sol or in_sof set, and it flips on every following valid pixel. Cycles with in_valid low do not advance it, and their markers are ignored.
- R3: A valid pixel with in_sof set has row parity 0 and also starts a line. Each later valid pixel with in_sol set (and in_sof clear) flips the row parity. Pixels arriving after reset, before any frame start, are treated as row 0.
- R4: out_data = min(4095, (pixel × gain + 128) >> 8), using the full 24-bit product.
- R5: A gain of 0x100 passes the pixel through unchanged.
- R6: A gain of 0 gives an output of 0.
- R7: A pixel accepted on clock edge N appears on the outputs after edge N+2. out_valid, out_sof and out_sol follow in_valid, in_valid&in_sof and in_valid&in_sol with the same two-cycle delay.
- R8: Whenever out_valid is low, out_data, out_sof and out_sol are 0. This includes the reset state.
- R9: Gains and phase_sel are taken on the same edge as the pixel they apply to. A change affects only pixels accepted after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Input pixel qualifier |
| in_sof | input | 1 | First pixel of a frame |
| in_sol | input | 1 | First pixel of a line |
| in_data | input | 12 | Raw pixel |
| gain_red | input | 12 | Gain for red sites, 4.8 unsigned |
| gain_gr | input | 12 | Gain for green sites on red rows |
| gain_gb | input | 12 | Gain for green sites on blue rows |
| gain_blue | input | 12 | Gain for blue sites |
| phase_sel | input | 2 | Colour of the first pixel of a frame |
| out_valid | output | 1 | Output pixel qualifier |
| out_sof | output | 1 | Delayed frame-start marker |
| out_sol | output | 1 | Delayed line-start marker |
| out_data | output | 12 | Gained, rounded, clamped pixel |

## Verification
Several properties are checked on every cycle:
- the two-cycle alignment of valid and markers;
- zero outputs while idle;
- unity and zero gain behaviour;
- full-scale saturation;
- the row-state moves on frame and line starts;
- column flipping between pixels.

Other behaviours show only in the bench's scenarios. These include the colour-to-gain mapping under all four phases, rounding at the half-LSB boundary, and the handling of marker pulses that arrive with valid low. Gain changes between frames are also covered there, checked against a model that tracks parity on its own.

// File: rtl/bdg_pkg.sv
package bdg_pkg;

    // Colour site index: {row bit, column bit} after phase adjustment
    typedef enum logic [1:0] {
        CH_RED   = 2'd0,
        CH_GR    = 2'd1,
        CH_GB    = 2'd2,
        CH_BLUE  = 2'd3
    } chan_e;

    // Row parity tracker states
    typedef enum logic [1:0] {
        ROW_IDLE = 2'd0,
        ROW_EVEN = 2'd1,
        ROW_ODD  = 2'd2
    } row_st_e;

endpackage

// File: rtl/bdg_parity_fsm.sv
module bdg_parity_fsm
    import bdg_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        in_valid,
    input  logic        in_sof,
    input  logic        in_sol,
    input  logic [1:0]  phase_sel,
    output chan_e       chan
);

    row_st_e st_q, st_d;
    logic    col_q;
    logic    col_cur;
    logic    row_cur;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= ROW_IDLE;
            col_q <= 1'b1;
        end else begin
            st_q <= st_d;
            if (in_valid) begin
                col_q <= col_cur;
            end
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        if (in_valid) begin
            if (in_sof) begin
                st_d = ROW_EVEN;
            end else if (in_sol) begin
                unique case (st_q)
                    ROW_IDLE: st_d = ROW_EVEN;
                    ROW_EVEN: st_d = ROW_ODD;
                    ROW_ODD:  st_d = ROW_EVEN;
                    default:  st_d = ROW_IDLE;
                endcase
            end
        end
    end

    // Outputs: parity of the pixel currently presented
    always_comb begin
        row_cur = (st_d == ROW_ODD);
        col_cur = (in_sof || in_sol) ? 1'b0 : ~col_q;
        chan    = chan_e'({row_cur ^ phase_sel[1], col_cur ^ phase_sel[0]});
    end

    p_frame_even_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sof) |=> (st_q == ROW_EVEN));

    p_row_flip_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sol && !in_sof && st_q == ROW_EVEN) |=> (st_q == ROW_ODD));

    p_col_alt_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && !in_sol && !in_sof) |=> (col_q != $past(col_q)));

    p_col_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (!in_valid) |=> ($stable(col_q) && $stable(st_q)));

endmodule

// File: rtl/bdg_gain_stage.sv
module bdg_gain_stage
    import bdg_pkg::*;
#(
    parameter int PIX_W  = 12,
    parameter int GAIN_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_sol,
    input  logic [PIX_W-1:0]  in_data,
    input  chan_e             chan,
    input  logic [GAIN_W-1:0] gain_red,
    input  logic [GAIN_W-1:0] gain_gr,
    input  logic [GAIN_W-1:0] gain_gb,
    input  logic [GAIN_W-1:0] gain_blue,
    output logic              s_valid,
    output logic              s_sof,
    output logic              s_sol,
    output logic [PIX_W-1:0]  s_pix,
    output logic [GAIN_W-1:0] s_gain
);

    logic [GAIN_W-1:0] gain_sel;

    always_comb begin
        unique case (chan)
            CH_RED:  gain_sel = gain_red;
            CH_GR:   gain_sel = gain_gr;
            CH_GB:   gain_sel = gain_gb;
            CH_BLUE: gain_sel = gain_blue;
            default: gain_sel = gain_red;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_valid <= 1'b0;
            s_sof   <= 1'b0;
            s_sol   <= 1'b0;
            s_pix   <= '0;
            s_gain  <= '0;
        end else begin
            s_valid <= in_valid;
            s_sof   <= in_valid && in_sof;
            s_sol   <= in_valid && in_sol;
            s_pix   <= in_valid ? in_data  : '0;
            s_gain  <= in_valid ? gain_sel : '0;
        end
    end

    p_stage_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !s_valid |-> (s_pix == '0 && !s_sof && !s_sol));

endmodule

// File: rtl/bdg_mul_sat.sv
module bdg_mul_sat #(
    parameter int PIX_W  = 12,
    parameter int GAIN_W = 12,
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              s_valid,
    input  logic              s_sof,
    input  logic              s_sol,
    input  logic [PIX_W-1:0]  s_pix,
    input  logic [GAIN_W-1:0] s_gain,
    output logic              o_valid,
    output logic              o_sof,
    output logic              o_sol,
    output logic [PIX_W-1:0]  o_data
);

    localparam int PROD_W = PIX_W + GAIN_W;
    localparam int SUM_W  = PROD_W + 1;
    localparam int SHR_W  = SUM_W - FRAC_W;
    localparam logic [SUM_W-1:0]  HALF  = SUM_W'(1) << (FRAC_W - 1);
    localparam logic [PIX_W-1:0]  MAXV  = '1;
    localparam logic [GAIN_W-1:0] UNITY = GAIN_W'(1) << FRAC_W;

    logic [PROD_W-1:0] prod;
    logic [SUM_W-1:0]  sum;
    logic [SHR_W-1:0]  shr;
    logic              ovf;
    logic [PIX_W-1:0]  clamped;

    always_comb begin
        prod    = PROD_W'(s_pix) * PROD_W'(s_gain);
        sum     = SUM_W'(prod) + HALF;
        shr     = sum[SUM_W-1:FRAC_W];
        ovf     = |shr[SHR_W-1:PIX_W];
        clamped = ovf ? MAXV : shr[PIX_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            o_valid <= 1'b0;
            o_sof   <= 1'b0;
            o_sol   <= 1'b0;
            o_data  <= '0;
        end else begin
            o_valid <= s_valid;
            o_sof   <= s_valid && s_sof;
            o_sol   <= s_valid && s_sol;
            o_data  <= s_valid ? clamped : '0;
        end
    end

    p_unity_pass_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_gain == UNITY) |=> (o_data == $past(s_pix)));

    p_zero_gain_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_gain == '0) |=> (o_data == '0));

    p_full_scale_sat_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (s_valid && s_pix == MAXV && s_gain > UNITY) |=> (o_data == MAXV));

    p_idle_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !o_valid |-> (o_data == '0 && !o_sof && !o_sol));

endmodule

// File: rtl/bayer_dgain.sv
module bayer_dgain
    import bdg_pkg::*;
#(
    parameter int PIX_W  = 12,
    parameter int GAIN_W = 12,
    parameter int FRAC_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic              in_sof,
    input  logic              in_sol,
    input  logic [PIX_W-1:0]  in_data,
    input  logic [GAIN_W-1:0] gain_red,
    input  logic [GAIN_W-1:0] gain_gr,
    input  logic [GAIN_W-1:0] gain_gb,
    input  logic [GAIN_W-1:0] gain_blue,
    input  logic [1:0]        phase_sel,
    output logic              out_valid,
    output logic              out_sof,
    output logic              out_sol,
    output logic [PIX_W-1:0]  out_data
);

    chan_e             chan;
    logic              s_valid, s_sof, s_sol;
    logic [PIX_W-1:0]  s_pix;
    logic [GAIN_W-1:0] s_gain;

    bdg_parity_fsm u_parity (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_sol    (in_sol),
        .phase_sel (phase_sel),
        .chan      (chan)
    );

    bdg_gain_stage #(.PIX_W(PIX_W), .GAIN_W(GAIN_W)) u_select (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (in_valid),
        .in_sof    (in_sof),
        .in_sol    (in_sol),
        .in_data   (in_data),
        .chan      (chan),
        .gain_red  (gain_red),
        .gain_gr   (gain_gr),
        .gain_gb   (gain_gb),
        .gain_blue (gain_blue),
        .s_valid   (s_valid),
        .s_sof     (s_sof),
        .s_sol     (s_sol),
        .s_pix     (s_pix),
        .s_gain    (s_gain)
    );

    bdg_mul_sat #(.PIX_W(PIX_W), .GAIN_W(GAIN_W), .FRAC_W(FRAC_W)) u_scale (
        .clk     (clk),
        .rst_n   (rst_n),
        .s_valid (s_valid),
        .s_sof   (s_sof),
        .s_sol   (s_sol),
        .s_pix   (s_pix),
        .s_gain  (s_gain),
        .o_valid (out_valid),
        .o_sof   (out_sof),
        .o_sol   (out_sol),
        .o_data  (out_data)
    );

    // Edges since reset release, saturating, so $past never reaches before reset
    logic [1:0] age_q;
    always_ff @(posedge clk) begin
        if (!rst_n)             age_q <= 2'd0;
        else if (age_q != 2'd2) age_q <= age_q + 2'd1;
    end

    p_latency_valid_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (out_valid == $past(in_valid, 2)));

    p_latency_marks_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (age_q == 2'd2) |-> (out_sof == $past(in_valid && in_sof, 2) &&
                             out_sol == $past(in_valid && in_sol, 2)));

endmodule

// File: tb/bayer_dgain_test.sv
module bayer_dgain_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sof = 1'b0, in_sol = 1'b0;
    logic [11:0] in_data = '0;
    logic [11:0] gain_red = 12'h100, gain_gr = 12'h100, gain_gb = 12'h100, gain_blue = 12'h100;
    logic [1:0]  phase_sel = 2'd0;
    logic        out_valid, out_sof, out_sol;
    logic [11:0] out_data;

    always #5 clk = ~clk;

    bayer_dgain uut (
        .clk(clk), .rst_n(rst_n),
        .in_valid(in_valid), .in_sof(in_sof), .in_sol(in_sol), .in_data(in_data),
        .gain_red(gain_red), .gain_gr(gain_gr), .gain_gb(gain_gb), .gain_blue(gain_blue),
        .phase_sel(phase_sel),
        .out_valid(out_valid), .out_sof(out_sof), .out_sol(out_sol), .out_data(out_data)
    );

    int total = 0;
    int bad = 0;
    int cyc = 0;
    bit done = 1'b0;
    bit monitor_on = 1'b0;

    int          due_q[$];
    logic [13:0] val_q[$];
    string       tag_q[$];

    int m_row = 0;
    int m_col = 1;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [11:0] model(input logic [11:0] p, input logic [11:0] g);
        longint r;
        r = (longint'(p) * longint'(g) + 128) >>> 8;
        if (r > 4095) r = 4095;
        return r[11:0];
    endfunction

    // Driver: called at a falling edge, drives one cycle, pushes expectation
    task automatic drive(input bit v, input bit sof, input bit sol,
                         input logic [11:0] d, input string tag);
        logic [11:0] g;
        int idx;
        in_valid = v; in_sof = sof; in_sol = sol; in_data = d;
        if (v) begin
            if (sof) begin m_row = 0; m_col = 0; end
            else if (sol) begin m_row = m_row ^ 1; m_col = 0; end
            else m_col = m_col ^ 1;
            idx = ((m_row ^ int'(phase_sel[1])) << 1) | (m_col ^ int'(phase_sel[0]));
            case (idx)
                0: g = gain_red;
                1: g = gain_gr;
                2: g = gain_gb;
                default: g = gain_blue;
            endcase
            due_q.push_back(cyc + 2);
            val_q.push_back({sof, sof | sol, model(d, g)});
            tag_q.push_back(tag);
        end
        @(negedge clk);
        in_valid = 1'b0; in_sof = 1'b0; in_sol = 1'b0; in_data = '0;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    // Monitor / scoreboard
    always @(negedge clk) begin
        if (monitor_on) begin
            if (out_valid) begin
                total++;
                if (due_q.size() == 0) begin
                    bad++;
                    $display("FAIL R7 unexpected output: got data=%0d expected none", out_data);
                end else begin
                    automatic int          d = due_q.pop_front();
                    automatic logic [13:0] v = val_q.pop_front();
                    automatic string       t = tag_q.pop_front();
                    if (d != cyc || out_data != v[11:0] || out_sof != v[13] || out_sol != v[12]) begin
                        bad++;
                        $display("FAIL %s/R7: got cyc=%0d data=%0d sof=%0b sol=%0b, expected cyc=%0d data=%0d sof=%0b sol=%0b",
                                 t, cyc, out_data, out_sof, out_sol, d, v[11:0], v[13], v[12]);
                    end
                end
            end else begin
                total++;
                if (out_data != 0 || out_sof || out_sol) begin
                    bad++;
                    $display("FAIL R8 idle outputs: got data=%0d sof=%0b sol=%0b, expected 0 0 0",
                             out_data, out_sof, out_sol);
                end
                if (due_q.size() > 0 && due_q[0] == cyc) begin
                    bad++;
                    $display("FAIL R7 missing output: got valid=0, expected valid=1 at cyc=%0d", cyc);
                    void'(due_q.pop_front()); void'(val_q.pop_front()); void'(tag_q.pop_front());
                end
            end
        end
    end

    task automatic frame(input int rows, input int cols, input bit gaps,
                         input int seed, input string tag);
        for (int r = 0; r < rows; r++) begin
            for (int c = 0; c < cols; c++) begin
                // R2: marker pulses with valid low must be ignored
                if (gaps && ((c + r) % 3 == 1)) drive(1'b0, 1'b1, 1'b1, 12'hABC, tag);
                drive(1'b1, (r == 0 && c == 0), (c == 0),
                      12'((seed + r * 733 + c * 397 + r * c * 19) % 4096), tag);
            end
            if (gaps) idle(2);
        end
    endtask

    task automatic summary;
        if (due_q.size() != 0) begin
            total++; bad++;
            $display("FAIL R7 outputs never produced: got %0d pending, expected 0", due_q.size());
        end
        $display("  test done: total=%0d bad=%0d", total, bad);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        total++;
        if (out_valid || out_sof || out_sol || out_data != 0) begin
            bad++;
            $display("FAIL R8 reset state: got v=%0b sof=%0b sol=%0b d=%0d, expected all 0",
                     out_valid, out_sof, out_sol, out_data);
        end
        rst_n = 1'b1;
        monitor_on = 1'b1;
        idle(2);

        // R5: unity passthrough; R3: pixels before any frame start are row 0
        drive(1'b1, 1'b0, 1'b0, 12'd77, "R3");
        frame(2, 6, 1'b0, 5, "R5");
        idle(3);

        // R1, R2, R3, R4: distinct gains under every phase, with gaps
        gain_red = 12'h180; gain_gr = 12'h0C0; gain_gb = 12'h200; gain_blue = 12'h0FF;
        for (int ph = 0; ph < 4; ph++) begin
            phase_sel = 2'(ph);
            frame(3, 5, 1'b1, 100 + ph * 31, "R1");
            idle(2);
        end

        // R4: saturation and rounding
        phase_sel = 2'd0;
        gain_red = 12'hFFF; gain_gr = 12'h080; gain_gb = 12'h07F; gain_blue = 12'h055;
        drive(1'b1, 1'b1, 1'b1, 12'd4095, "R4");   // red: clamps to 4095
        drive(1'b1, 1'b0, 1'b0, 12'd1,    "R4");   // gr: 1*0x80 rounds up to 1
        drive(1'b1, 1'b0, 1'b0, 12'd1500, "R4");   // red: clamps
        drive(1'b1, 1'b0, 1'b0, 12'd16,   "R4");   // gr: 16*0x80 -> 8
        drive(1'b1, 1'b1, 1'b1, 12'd16,   "R4");   // red: 16*0xFFF -> 256, no clamp
        drive(1'b1, 1'b0, 1'b1, 12'd1,    "R4");   // row 1 col 0 -> gb: 1*0x7F -> 0
        drive(1'b1, 1'b0, 1'b0, 12'd3,    "R4");   // blue: 3*0x55 -> 1
        idle(3);

        // R6: zero gain on all sites
        gain_red = 12'h000; gain_gr = 12'h000; gain_gb = 12'h000; gain_blue = 12'h000;
        frame(2, 4, 1'b0, 900, "R6");

        // R9: gain changed between pixels affects only later pixels
        gain_red = 12'h200; gain_gr = 12'h200;
        drive(1'b1, 1'b1, 1'b1, 12'd100, "R9");
        gain_gr = 12'h300;
        drive(1'b1, 1'b0, 1'b0, 12'd100, "R9");
        gain_red = 12'h100;
        drive(1'b1, 1'b0, 1'b0, 12'd100, "R9");
        idle(5);

        done = 1'b1;
        summary();
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: got no completion, expected end of scenarios");
            summary();
            $finish;
        end
    end

endmodule